// File: doc/BRIEF.md
# Instruction Reuse Buffer

This block is a set-associative store of already computed instruction results. Each stored entry is keyed by the instruction address. Alongside the result it keeps the names of the source registers the instruction read. When the same instruction is fetched again, a reuse probe with its current operand names asks whether the stored result can be committed directly, so the instruction need not execute.

An entry is either a chain head or a chained entry. A chain head stays trustworthy until one of its source registers is written; a register-write snoop port clears it at that point. A chained entry carries a link to the slot of the instruction that produced its input. It may be reused only after that producer has itself been reused, so a chain can only be replayed from the front. Inserts land in a same-address way, a free way or the least recently used way. Overwriting a slot cuts every link that points at it.

Top module: `instr_reuse_buf`

## Requirements
- R1: After a synchronous active-high reset every entry is empty, so every probe misses until an insert has been made.
- R2: A probe hits only when all of the following hold: a valid entry in set `pc[2 +: log2(SETS)]` holds the same address; its first source name matches; its "second source used" flag matches; and, when that flag is set, its second source name matches. On a hit the stored result and the slot index `{set, way}` appear combinationally in the same cycle.
- R3: A probe with `test_valid` low, or with `test_ready` low (inputs not yet available), always misses.
- R4: A register write whose register equals a used source of a valid chain-head entry clears that entry from the next clock edge. Later probes miss until the entry is inserted again.
- R5: If a probe and a register write arrive in the same cycle and the written register is a used source of the chain-head entry being probed, the probe misses.
- R6: A chained entry hits only while the slot named by its link is valid and has been reused since it was last inserted. Register writes do not clear chained entries directly.
- R7: A hit marks the hit slot as reused from the next clock edge. An insert into a slot, or the invalidation of a slot, clears its reused mark.
- R8: An insert goes to the lowest way holding the same address as a valid entry; otherwise to the lowest invalid way; otherwise to the least recently used way. `ins_idx` shows that slot combinationally in the cycle of the insert. The inserted entry is valid and not reused.
- R9: Hits and inserts each make their way the most recently used in its set. When both occur in one cycle, the hit is applied first and the insert second.
- R10: Inserting into a slot clears every valid chained entry whose link names that slot.
- R11: On a miss, `test_result` and `test_idx` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_valid | input | 1 | Reuse probe request |
| test_ready | input | 1 | Probe inputs are available |
| test_pc | input | PC_W | Address of the probed instruction |
| test_src1 | input | 5 | First source register name |
| test_src2 | input | 5 | Second source register name |
| test_src2_used | input | 1 | Probed instruction reads a second source |
| test_hit | output | 1 | Stored result may be committed |
| test_result | output | DATA_W | Stored result on a hit, zero otherwise |
| test_idx | output | log2(SETS*WAYS) | Hit slot `{set, way}`, zero otherwise |
| ins_valid | input | 1 | Record an executed instruction |
| ins_pc | input | PC_W | Address of the recorded instruction |
| ins_src1 | input | 5 | First source register name |
| ins_src2 | input | 5 | Second source register name |
| ins_src2_used | input | 1 | Recorded instruction reads a second source |
| ins_chained | input | 1 | Entry depends on a producer slot |
| ins_link | input | log2(SETS*WAYS) | Producer slot index |
| ins_result | input | DATA_W | Result to store |
| ins_idx | output | log2(SETS*WAYS) | Slot chosen for the insert |
| wr_en | input | 1 | A register is being written |
| wr_reg | input | 5 | Name of the written register |

## Verification
The hardest state to reach is a chained entry whose producer is valid but has lost its reused mark, or whose producer slot has just been refilled. Only a particular order of insert, probe, register write and re-insert gets there. A directed sequence builds a two-link chain, probes the tail before and after the head is reused, then kills the head by a write and re-inserts it. A further directed sequence forces an LRU eviction. After that, a long random phase runs on a small geometry: six addresses per set, eight register names, and operands drawn from a per-address table. This keeps hits, evictions, cut links and same-cycle write/probe collisions frequent. A behavioural model compares every output on every cycle.

// File: rtl/irb_pkg.sv
package irb_pkg;
    localparam int REG_W = 5;

    typedef logic [REG_W-1:0] reg_id_t;

    typedef struct packed {
        reg_id_t src1;
        reg_id_t src2;
        logic    src2_used;
    } opnds_t;

    // Operand names agree; the second name only counts when it is read.
    function automatic logic opnds_same(opnds_t a, opnds_t b);
        return (a.src1 == b.src1) && (a.src2_used == b.src2_used) &&
               (!a.src2_used || (a.src2 == b.src2));
    endfunction

    // Register r is one of the sources that the entry actually reads.
    function automatic logic opnds_read(opnds_t o, reg_id_t r);
        return (o.src1 == r) || (o.src2_used && (o.src2 == r));
    endfunction
endpackage

// File: rtl/irb_lru.sv
module irb_lru #(
    parameter int SETS = 1024,
    parameter int WAYS = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     hit_en,
    input  logic [$clog2(SETS)-1:0]  hit_set,
    input  logic [$clog2(WAYS)-1:0]  hit_way,
    input  logic                     ins_en,
    input  logic [$clog2(SETS)-1:0]  ins_set,
    input  logic [$clog2(WAYS)-1:0]  ins_way,
    input  logic [$clog2(SETS)-1:0]  q_set,
    output logic [$clog2(WAYS)-1:0]  q_oldest
);
    localparam int WAY_W = $clog2(WAYS);

    // Per-way age rank: 0 = most recent, WAYS-1 = least recent.
    logic [WAY_W-1:0] age_q  [SETS][WAYS];
    logic [WAY_W-1:0] row_h  [WAYS];
    logic [WAY_W-1:0] row_hn [WAYS];
    logic [WAY_W-1:0] row_ib [WAYS];
    logic [WAY_W-1:0] row_in [WAYS];
    logic [WAYS-1:0]  old_v;

    always_comb begin
        for (int w = 0; w < WAYS; w++) row_h[w] = age_q[hit_set][w];
        for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == hit_way)          row_hn[w] = '0;
            else if (row_h[w] < row_h[hit_way]) row_hn[w] = row_h[w] + 1'b1;
            else                                row_hn[w] = row_h[w];
        end
        // Insert touch is applied on top of a same-set hit touch.
        for (int w = 0; w < WAYS; w++)
            row_ib[w] = (hit_en && ins_set == hit_set) ? row_hn[w] : age_q[ins_set][w];
        for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == ins_way)            row_in[w] = '0;
            else if (row_ib[w] < row_ib[ins_way]) row_in[w] = row_ib[w] + 1'b1;
            else                                  row_in[w] = row_ib[w];
        end
    end

    always_comb begin
        q_oldest = '0;
        for (int w = 0; w < WAYS; w++) begin
            old_v[w] = (age_q[q_set][w] == WAY_W'(WAYS - 1));
            if (old_v[w]) q_oldest = WAY_W'(w);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= WAY_W'(w);
        end else begin
            if (hit_en)
                for (int w = 0; w < WAYS; w++) age_q[hit_set][w] <= row_hn[w];
            if (ins_en)
                for (int w = 0; w < WAYS; w++) age_q[ins_set][w] <= row_in[w];
        end
    end

    // Ranks stay a permutation, so exactly one way is the eviction candidate.
    assert_lru_rank_R9: assert property (@(posedge clk) disable iff (rst)
        $countones(old_v) == 1)
        else $error("LRU ranks in queried set are not a permutation");
endmodule

// File: rtl/irb_match.sv
module irb_match
    import irb_pkg::*;
#(
    parameter int WAYS = 4
) (
    input  logic                     probe,
    input  opnds_t                   want,
    input  logic                     wr_en,
    input  reg_id_t                  wr_reg,
    input  logic   [WAYS-1:0]        way_live,
    input  opnds_t [WAYS-1:0]        way_ops,
    input  logic   [WAYS-1:0]        way_chained,
    input  logic   [WAYS-1:0]        way_pred_reused,
    output logic                     hit,
    output logic [$clog2(WAYS)-1:0]  hit_way
);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAYS-1:0] cand;

    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            cand[w] = probe && way_live[w] && opnds_same(way_ops[w], want) &&
                      (way_chained[w] ? way_pred_reused[w]
                                      : !(wr_en && opnds_read(way_ops[w], wr_reg)));
            if (cand[w] && !hit) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/instr_reuse_buf.sv
module instr_reuse_buf
    import irb_pkg::*;
#(
    parameter int SETS   = 1024,
    parameter int WAYS   = 4,
    parameter int PC_W   = 32,
    parameter int DATA_W = 32
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                test_valid,
    input  logic                                test_ready,
    input  logic [PC_W-1:0]                     test_pc,
    input  logic [4:0]                          test_src1,
    input  logic [4:0]                          test_src2,
    input  logic                                test_src2_used,
    output logic                                test_hit,
    output logic [DATA_W-1:0]                   test_result,
    output logic [$clog2(SETS*WAYS)-1:0]        test_idx,
    input  logic                                ins_valid,
    input  logic [PC_W-1:0]                     ins_pc,
    input  logic [4:0]                          ins_src1,
    input  logic [4:0]                          ins_src2,
    input  logic                                ins_src2_used,
    input  logic                                ins_chained,
    input  logic [$clog2(SETS*WAYS)-1:0]        ins_link,
    input  logic [DATA_W-1:0]                   ins_result,
    output logic [$clog2(SETS*WAYS)-1:0]        ins_idx,
    input  logic                                wr_en,
    input  logic [4:0]                          wr_reg
);
    localparam int ENTRIES = SETS * WAYS;
    localparam int SET_W   = $clog2(SETS);
    localparam int WAY_W   = $clog2(WAYS);
    localparam int IDX_W   = SET_W + WAY_W;
    localparam int PC_LSB  = 2;
    localparam int TAG_W   = PC_W - SET_W;

    // Entry storage.
    logic [TAG_W-1:0]  tag_q  [ENTRIES];
    opnds_t            opnd_q [ENTRIES];
    logic [IDX_W-1:0]  link_q [ENTRIES];
    logic [DATA_W-1:0] res_q  [ENTRIES];
    logic [ENTRIES-1:0] chn_q, vld_q, rsd_q;

    // Address split: set index above the byte offset, everything else is tag.
    logic [SET_W-1:0] t_set, i_set;
    logic [TAG_W-1:0] t_tag, i_tag;
    assign t_set = test_pc[PC_LSB +: SET_W];
    assign i_set = ins_pc[PC_LSB +: SET_W];
    assign t_tag = {test_pc[PC_W-1:PC_LSB+SET_W], test_pc[PC_LSB-1:0]};
    assign i_tag = {ins_pc[PC_W-1:PC_LSB+SET_W], ins_pc[PC_LSB-1:0]};

    opnds_t want, ins_ops;
    assign want    = '{src1: test_src1, src2: test_src2, src2_used: test_src2_used};
    assign ins_ops = '{src1: ins_src1, src2: ins_src2, src2_used: ins_src2_used};

    // Probe side: gather the ways of the probed set.
    logic   [WAYS-1:0] way_live, way_chn, way_prd;
    opnds_t [WAYS-1:0] way_ops;
    logic              m_hit;
    logic [WAY_W-1:0]  m_way;
    logic [IDX_W-1:0]  hit_slot;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            logic [IDX_W-1:0] s;
            s           = {t_set, WAY_W'(w)};
            way_live[w] = vld_q[s] && (tag_q[s] == t_tag);
            way_ops[w]  = opnd_q[s];
            way_chn[w]  = chn_q[s];
            way_prd[w]  = rsd_q[link_q[s]];
        end
    end

    irb_match #(.WAYS(WAYS)) u_match (
        .probe           (test_valid && test_ready),
        .want            (want),
        .wr_en           (wr_en),
        .wr_reg          (wr_reg),
        .way_live        (way_live),
        .way_ops         (way_ops),
        .way_chained     (way_chn),
        .way_pred_reused (way_prd),
        .hit             (m_hit),
        .hit_way         (m_way)
    );

    assign hit_slot    = {t_set, m_way};
    assign test_hit    = m_hit;
    assign test_idx    = m_hit ? hit_slot : '0;
    assign test_result = m_hit ? res_q[hit_slot] : '0;

    // Insert side: same address, then free way, then least recently used.
    logic [WAY_W-1:0] lru_way, vic_way;
    logic             have_same, have_free;

    always_comb begin
        have_same = 1'b0;
        have_free = 1'b0;
        vic_way   = lru_way;
        for (int w = WAYS - 1; w >= 0; w--) begin
            logic [IDX_W-1:0] s;
            s = {i_set, WAY_W'(w)};
            if (!vld_q[s] && !have_same) begin
                have_free = 1'b1;
                vic_way   = WAY_W'(w);
            end
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            logic [IDX_W-1:0] s;
            s = {i_set, WAY_W'(w)};
            if (vld_q[s] && tag_q[s] == i_tag) begin
                have_same = 1'b1;
                vic_way   = WAY_W'(w);
            end
        end
    end

    assign ins_idx = {i_set, vic_way};

    irb_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk      (clk),
        .rst      (rst),
        .hit_en   (m_hit),
        .hit_set  (t_set),
        .hit_way  (m_way),
        .ins_en   (ins_valid),
        .ins_set  (i_set),
        .ins_way  (vic_way),
        .q_set    (i_set),
        .q_oldest (lru_way)
    );

    // Payload storage: no reset needed, guarded by vld_q.
    always_ff @(posedge clk) begin
        if (ins_valid) begin
            tag_q[ins_idx]  <= i_tag;
            opnd_q[ins_idx] <= ins_ops;
            link_q[ins_idx] <= ins_link;
            res_q[ins_idx]  <= ins_result;
        end
    end

    // Flags: hit mark, then snoop and link-cut clears, then the insert.
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            rsd_q <= '0;
            chn_q <= '0;
        end else begin
            if (m_hit) rsd_q[hit_slot] <= 1'b1;
            for (int j = 0; j < ENTRIES; j++) begin
                if (vld_q[j] && !chn_q[j] && wr_en && opnds_read(opnd_q[j], wr_reg)) begin
                    vld_q[j] <= 1'b0;
                    rsd_q[j] <= 1'b0;
                end
                if (vld_q[j] && chn_q[j] && ins_valid && link_q[j] == ins_idx) begin
                    vld_q[j] <= 1'b0;
                    rsd_q[j] <= 1'b0;
                end
            end
            if (ins_valid) begin
                vld_q[ins_idx] <= 1'b1;
                rsd_q[ins_idx] <= 1'b0;
                chn_q[ins_idx] <= ins_chained;
            end
        end
    end

    assert_gate_R3: assert property (@(posedge clk) disable iff (rst)
        test_hit |-> (test_valid && test_ready))
        else $error("hit without a ready, valid probe");

    assert_zero_miss_R11: assert property (@(posedge clk) disable iff (rst)
        !test_hit |-> (test_result == '0 && test_idx == '0))
        else $error("miss drives nonzero result or index");

    assert_hit_marks_R7: assert property (@(posedge clk) disable iff (rst)
        (test_hit && !ins_valid) |=> rsd_q[$past(test_idx)])
        else $error("hit slot not marked reused");

    assert_insert_fresh_R8: assert property (@(posedge clk) disable iff (rst)
        ins_valid |=> (vld_q[$past(ins_idx)] && !rsd_q[$past(ins_idx)]))
        else $error("inserted slot not valid and fresh");
endmodule

// File: tb/instr_reuse_buf_bench.sv
module instr_reuse_buf_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SETS = 8;
    localparam int WAYS = 4;
    localparam int N    = SETS * WAYS;
    localparam int IW   = 5;

    logic clk = 1'b0;
    logic rst;
    logic tv, tr, tu, iv, iu, ich, we;
    logic [31:0] tpc, ipc, ires;
    logic [4:0]  ts1, ts2, is1, is2, wreg;
    logic [IW-1:0] ilk;
    logic          hit;
    logic [31:0]   res;
    logic [IW-1:0] idx, iidx;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    instr_reuse_buf #(.SETS(SETS), .WAYS(WAYS), .PC_W(32), .DATA_W(32)) u_instr_reuse_buf (
        .clk(clk), .rst(rst),
        .test_valid(tv), .test_ready(tr), .test_pc(tpc), .test_src1(ts1),
        .test_src2(ts2), .test_src2_used(tu), .test_hit(hit), .test_result(res),
        .test_idx(idx),
        .ins_valid(iv), .ins_pc(ipc), .ins_src1(is1), .ins_src2(is2),
        .ins_src2_used(iu), .ins_chained(ich), .ins_link(ilk), .ins_result(ires),
        .ins_idx(iidx),
        .wr_en(we), .wr_reg(wreg)
    );

    // Behavioural reference state.
    bit mv[N], mr[N], mc[N], mu[N];
    int ms1[N], ms2[N], mlk[N], mage[N];
    logic [31:0] mpc[N], mres[N];

    function automatic int setof(logic [31:0] pc);
        return int'((pc >> 2) & (SETS - 1));
    endfunction

    function automatic bit uses(int j, int r);
        return ms1[j] == r || (mu[j] && ms2[j] == r);
    endfunction

    function automatic int victim();
        int b = setof(ipc) * WAYS;
        for (int w = 0; w < WAYS; w++) if (mv[b+w] && mpc[b+w] == ipc) return b + w;
        for (int w = 0; w < WAYS; w++) if (!mv[b+w]) return b + w;
        for (int w = 0; w < WAYS; w++) if (mage[b+w] == WAYS - 1) return b + w;
        return b;
    endfunction

    task automatic touch(int j);
        int b = (j / WAYS) * WAYS;
        int a = mage[j];
        for (int k = 0; k < WAYS; k++) if (mage[b+k] < a) mage[b+k]++;
        mage[j] = 0;
    endtask

    task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    // Called at a falling edge with inputs set; checks, advances model, waits one cycle.
    task automatic cyc(string tag);
        bit h = 0;
        int hs = 0;
        int vs = 0;
        #1;
        if (tv && tr) begin
            int b = setof(tpc) * WAYS;
            for (int w = 0; w < WAYS; w++) begin
                int j = b + w;
                if (!h && mv[j] && mpc[j] == tpc && ms1[j] == int'(ts1) && mu[j] == tu &&
                    (!tu || ms2[j] == int'(ts2)) &&
                    (mc[j] ? mr[mlk[j]] : !(we && uses(j, int'(wreg))))) begin
                    h = 1; hs = j;
                end
            end
        end
        if (iv) vs = victim();
        check(tag, "hit", 32'(hit), 32'(h));
        check(tag, "result", res, h ? mres[hs] : 32'h0);
        check(tag, "index", 32'(idx), h ? 32'(hs) : 32'h0);
        if (iv) check(tag, "insert slot", 32'(iidx), 32'(vs));
        if (h) begin mr[hs] = 1; touch(hs); end
        for (int j = 0; j < N; j++) begin
            if (mv[j] && !mc[j] && we && uses(j, int'(wreg))) begin mv[j] = 0; mr[j] = 0; end
            if (mv[j] && mc[j] && iv && mlk[j] == vs) begin mv[j] = 0; mr[j] = 0; end
        end
        if (iv) begin
            mv[vs] = 1; mr[vs] = 0; mc[vs] = ich; mpc[vs] = ipc; mres[vs] = ires;
            ms1[vs] = int'(is1); ms2[vs] = int'(is2); mu[vs] = iu; mlk[vs] = int'(ilk);
            touch(vs);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        tv = 0; tr = 1; iv = 0; we = 0;
    endtask

    task automatic probe(logic [31:0] pc, int s1, int s2, bit u, bit rdy);
        tv = 1; tpc = pc; ts1 = 5'(s1); ts2 = 5'(s2); tu = u; tr = rdy;
    endtask

    task automatic put(logic [31:0] pc, int s1, int s2, bit u, bit ch, int lk, logic [31:0] r);
        iv = 1; ipc = pc; is1 = 5'(s1); is2 = 5'(s2); iu = u; ich = ch; ilk = IW'(lk); ires = r;
    endtask

    int ps1[48], ps2[48];
    bit pu[48];
    int last_ins;
    bit done = 0;

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tpc = 0; ts1 = 0; ts2 = 0; tu = 0; ipc = 0; is1 = 0; is2 = 0; iu = 0;
        ich = 0; ilk = 0; ires = 0; wreg = 0;
        idle();
        rst = 1;
        for (int j = 0; j < N; j++) begin mv[j] = 0; mr[j] = 0; mage[j] = j % WAYS; end
        repeat (3) @(negedge clk);
        rst = 0;

        probe(32'h10, 1, 2, 1, 1); cyc("R1");
        idle(); put(32'h10, 1, 2, 1, 0, 0, 32'hAAAA); cyc("R8");
        put(32'h14, 5, 0, 0, 1, 16, 32'hBBBB); cyc("R8");
        idle(); probe(32'h14, 5, 0, 0, 1); cyc("R6");
        probe(32'h10, 1, 2, 1, 1); cyc("R2");
        probe(32'h10, 1, 3, 1, 1); cyc("R2");
        probe(32'h10, 1, 2, 0, 1); cyc("R11");
        probe(32'h10, 1, 2, 1, 0); cyc("R3");
        probe(32'h14, 5, 0, 0, 1); cyc("R7");
        probe(32'h10, 1, 2, 1, 1); we = 1; wreg = 2; cyc("R5");
        we = 0; cyc("R4");
        probe(32'h14, 5, 0, 0, 1); cyc("R6");
        idle(); put(32'h10, 1, 2, 1, 0, 0, 32'hAAAB); cyc("R10");
        idle(); probe(32'h10, 1, 2, 1, 1); cyc("R4");
        probe(32'h14, 5, 0, 0, 1); cyc("R10");
        idle();
        for (int k = 0; k < 4; k++) begin
            put(32'(k * 32), 3, 4, 1, 0, 0, 32'(100 + k)); cyc("R8");
        end
        idle(); probe(32'h0, 3, 4, 1, 1); cyc("R9");
        idle(); put(32'h80, 3, 4, 1, 0, 0, 32'h200); cyc("R9");
        idle(); probe(32'h20, 3, 4, 1, 1); cyc("R9");
        probe(32'h0, 3, 4, 1, 1); cyc("R9");

        for (int p = 0; p < 48; p++) begin
            ps1[p] = $urandom_range(0, 7); ps2[p] = $urandom_range(0, 7); pu[p] = 1'($urandom_range(0, 1));
        end
        last_ins = 0;
        for (int n = 0; n < 4000; n++) begin
            int p = $urandom_range(0, 47);
            int q = $urandom_range(0, 47);
            idle();
            if ($urandom_range(0, 9) < 7) begin
                if ($urandom_range(0, 9) < 8) probe(32'(p * 4), ps1[p], ps2[p], pu[p], $urandom_range(0, 9) != 0);
                else probe(32'(p * 4), $urandom_range(0, 7), $urandom_range(0, 7), 1'($urandom_range(0, 1)), 1);
            end
            if ($urandom_range(0, 9) < 3) begin
                if ($urandom_range(0, 9) == 0) begin
                    ps1[q] = $urandom_range(0, 7); ps2[q] = $urandom_range(0, 7); pu[q] = 1'($urandom_range(0, 1));
                end
                put(32'(q * 4), ps1[q], ps2[q], pu[q], $urandom_range(0, 9) < 4,
                    ($urandom_range(0, 3) != 0) ? last_ins : $urandom_range(0, N - 1), $urandom);
            end
            if ($urandom_range(0, 9) < 2) begin we = 1; wreg = 5'($urandom_range(0, 7)); end
            if (iv) begin #1; last_ins = int'(iidx); #0; end
            cyc("R2");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule